// File: doc/BRIEF.md
# Direct 2-D DCT Input Reorder Buffer

This block sits in front of a parallel distributed-arithmetic 2-D DCT core that uses the direct method. It accepts one 8x8 block of signed 9-bit residues, one sample per accepted cycle, in raster order (row index first, then column index). Each sample is written to a permuted position. Within each row the column index is replaced by the index that the direct method's modular congruence assigns to it.

Two storage banks alternate. While one bank is filled by the producer, the other holds a complete block for the core. When the core raises its request line and a complete block is waiting, the block is streamed out bit-serially. Each pass lasts one cycle per bit position and presents one bit of all 64 stored words per cycle, least significant bit first, ending on the sign bit. Strobes mark the first and the last cycle of a pass. The producer is held off with a ready line while the bank it would write next still holds a block that has not been streamed.

Top module: `dct_in_reorder`

## Requirements
- R1: A synchronous active-low reset empties both banks and clears the write counter and the read state. After reset, `in_ready` is 1 and `out_valid` is 0. A block interrupted by reset is discarded, and the next block is collected from its first word.
- R2: The sample accepted as the k-th word of a block (row n1 = k/8, column n2 = k%8) is stored at stream index 8*n1 + t. Here t in 0..7 satisfies (4t+1)(4*n1+1) = 4*n2+1 modulo 32. For row 0 this means t equals n2.
- R3: During pass cycle b (b = 0..8), bit i of `out_bits` equals bit b of the 9-bit two's-complement word stored at stream index i. Bit 8 is the sign bit.
- R4: A pass is 9 consecutive cycles with `out_valid` high. `out_first` is high only in cycle 0 and `out_last` only in cycle 8. `out_valid` is low in the cycle after a pass ends.
- R5: With `core_req` held high and the other bank empty, the clock edge that accepts the 64th word is followed by one idle cycle. Cycle 0 of the pass is then presented after the next edge. No pass begins for a partially written block.
- R6: While both banks hold unread blocks, `in_ready` is 0 and words offered on `in_valid` are ignored: both stored blocks later stream out unchanged.
- R7: Blocks are streamed in the order in which they were completed, alternating between the two banks.
- R8: A pass begins only after a clock edge at which `core_req` is high and a complete block is waiting. With `core_req` low, `out_valid` stays 0.
- R9: A new block may be written while the previous one is being streamed, and neither block is corrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered on `in_sample` |
| in_ready | output | 1 | The block accepts the offered sample at this edge |
| in_sample | input | 9 | Signed residue, two's complement, raster order |
| core_req | input | 1 | Core is free to take the next pass |
| out_bits | output | 64 | One bit of each stored word, indexed by stream position |
| out_valid | output | 1 | A pass cycle is being presented |
| out_first | output | 1 | Pass cycle 0 (bit 0 of every word) |
| out_last | output | 1 | Pass cycle 8 (sign bit of every word) |

## Verification
The bench targets the permutation rows where the congruence scrambles the order most, such as rows 1 and 7. A map that was only a column copy, or that read the modulus wrongly, would put those samples at the wrong stream index. Extreme values of +255 and -255 and negative patterns check bit ordering and the sign bit. A reversed or off-by-one bit counter would return wrong words or move the strobes. A hold test fills both banks with the core idle and then offers more words. A ready line that ignored the second bank would overwrite an unread block, and a wrong bank pointer would stream the blocks out of order. A mid-block reset followed by a fresh block shows whether a stale write counter lingers.

// File: rtl/dct_reorder_pkg.sv
// Package: shared constants and types for the direct 2-D DCT reorder buffer.
// Assumes: block edge is a power of two; two banks operate in ping-pong.
package dct_reorder_pkg;

    // Default block edge length and sample width.
    localparam int unsigned DEF_BLK_N    = 8;
    localparam int unsigned DEF_SAMPLE_W = 9;

    // Bank selector: one of two banks.
    typedef logic bank_sel_t;

    // Read side state.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_PASS = 1'b1
    } rd_state_e;

endpackage

// File: rtl/dctr_index_map.sv
// Module: dctr_index_map
// Computes the in-row destination index t for a sample at (row, col) such that
// (4t+1)(4*row+1) == 4*col+1 modulo 4*BLK_N.
// Assumes: BLK_N is a power of two, so each row's map is a permutation.
module dctr_index_map #(
    parameter int unsigned BLK_N = 8
) (
    input  logic [$clog2(BLK_N)-1:0] row,
    input  logic [$clog2(BLK_N)-1:0] col,
    output logic [$clog2(BLK_N)-1:0] tpos
);
    localparam int unsigned IDX_W = $clog2(BLK_N);
    localparam int          MODV  = 4 * BLK_N;

    // Search the candidates for the one that satisfies the congruence.
    always_comb begin
        tpos = '0;
        for (int k = 0; k < BLK_N; k++) begin
            if ((((4 * k + 1) * (4 * int'(row) + 1)) % MODV) == (4 * int'(col) + 1)) begin
                tpos = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/dctr_write_ctrl.sv
// Module: dctr_write_ctrl
// Raster-order word counter for the write side; splits the count into row and
// column and flags the acceptance of the final word of a block.
// Assumes: `accept` is only high when the target bank is free.
module dctr_write_ctrl #(
    parameter int unsigned BLK_N = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    output logic [$clog2(BLK_N)-1:0] row,
    output logic [$clog2(BLK_N)-1:0] col,
    output logic                     blk_done
);
    localparam int unsigned IDX_W = $clog2(BLK_N);
    localparam int unsigned CNT_W = 2 * IDX_W;

    logic [CNT_W-1:0] cnt;

    // Advance the word counter on each accepted sample, wrapping per block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign row      = cnt[CNT_W-1:IDX_W];
    assign col      = cnt[IDX_W-1:0];
    assign blk_done = accept && (&cnt);

    // R2: the row steps by one when the last column of a non-final row is taken.
    p_row_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (&col) && !(&row)) |=> (row == $past(row) + 1'b1) && (col == '0));

    // R5: after the final word the counter starts a new block at the origin.
    p_wrap_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> (row == '0) && (col == '0));

endmodule

// File: rtl/dctr_pingpong.sv
// Module: dctr_pingpong
// Holds the two bank-full flags and the write and read bank pointers.
// A completed write fills the write bank and moves the write pointer; a
// finished pass empties the read bank and moves the read pointer.
// Assumes: the writer never completes into a full bank, the reader only
// finishes a pass on a full bank.
module dctr_pingpong
    import dct_reorder_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_done,
    input  logic      rd_done,
    output bank_sel_t wr_bank,
    output bank_sel_t rd_bank,
    output logic [1:0] full
);
    // Update fill flags and bank pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 2'b00;
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
        end else begin
            if (wr_done) begin
                full[wr_bank] <= 1'b1;
                wr_bank       <= ~wr_bank;
            end
            if (rd_done) begin
                full[rd_bank] <= 1'b0;
                rd_bank       <= ~rd_bank;
            end
        end
    end

    // R7: a pass only ends on a bank that holds a block.
    p_read_from_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> full[rd_bank]);

    // R6: a block never completes into a bank still holding an unread block.
    p_write_into_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !full[wr_bank]);

endmodule

// File: rtl/dctr_read_ctrl.sv
// Module: dctr_read_ctrl
// Sequences one bit-serial pass: bit index 0 up to SAMPLE_W-1, with strobes
// on the first and the last cycle. A pass starts from idle when a block is
// waiting and the core requests it; one idle cycle separates passes.
// Assumes: `bank_ready` stays high for the whole pass.
module dctr_read_ctrl
    import dct_reorder_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bank_ready,
    input  logic                        core_req,
    output logic                        active,
    output logic [$clog2(SAMPLE_W)-1:0] bit_idx,
    output logic                        pass_first,
    output logic                        pass_last
);
    localparam int unsigned          BIT_W    = $clog2(SAMPLE_W);
    localparam logic [BIT_W-1:0]     LAST_BIT = BIT_W'(SAMPLE_W - 1);

    rd_state_e state;

    // Step the pass state and the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            bit_idx <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    bit_idx <= '0;
                    if (bank_ready && core_req) begin
                        state <= RD_PASS;
                    end
                end
                RD_PASS: begin
                    if (bit_idx == LAST_BIT) begin
                        state   <= RD_IDLE;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign active     = (state == RD_PASS);
    assign pass_first = active && (bit_idx == '0);
    assign pass_last  = active && (bit_idx == LAST_BIT);

    // R3: inside a pass the bit index climbs by one each cycle.
    p_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pass_last) |=> (active && (bit_idx == $past(bit_idx) + 1'b1)));

    // R4: the cycle after the last bit is idle.
    p_gap_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_last |=> !active);

    // R4: every pass opens on its first-bit cycle.
    p_open_on_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> pass_first);

endmodule

// File: rtl/dctr_bank_store.sv
// Module: dctr_bank_store
// Two banks of WORDS samples. One write port takes a full word; the read port
// returns one selected bit of every word of the read bank.
// Assumes: no reset on storage; validity is tracked by the bank flags.
module dctr_bank_store
    import dct_reorder_pkg::*;
#(
    parameter int unsigned WORDS    = 64,
    parameter int unsigned SAMPLE_W = 9
) (
    input  logic                        clk,
    input  logic                        we,
    input  bank_sel_t                   wbank,
    input  logic [$clog2(WORDS)-1:0]    waddr,
    input  logic [SAMPLE_W-1:0]         wdata,
    input  bank_sel_t                   rbank,
    input  logic [$clog2(SAMPLE_W)-1:0] rbit,
    output logic [WORDS-1:0]            slice
);
    logic [SAMPLE_W-1:0] mem [2][WORDS];

    // Write one sample into the selected bank.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wbank][waddr] <= wdata;
        end
    end

    // Gather the selected bit from every word of the read bank.
    for (genvar w = 0; w < WORDS; w++) begin : g_slice
        assign slice[w] = mem[rbank][w][rbit];
    end

endmodule

// File: rtl/dct_in_reorder.sv
// Module: dct_in_reorder (top)
// Input reorder buffer for a direct-method 2-D DCT core: raster samples are
// written to modular-permuted positions in a ping-pong pair of banks and each
// complete block is streamed out bit-serially, LSB first, on request.
// Assumes: samples are two's complement; the core consumes a pass without stalls.
module dct_in_reorder
    import dct_reorder_pkg::*;
#(
    parameter int unsigned BLK_N    = DEF_BLK_N,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [SAMPLE_W-1:0]       in_sample,
    input  logic                      core_req,
    output logic [BLK_N*BLK_N-1:0]    out_bits,
    output logic                      out_valid,
    output logic                      out_first,
    output logic                      out_last
);
    localparam int unsigned IDX_W  = $clog2(BLK_N);
    localparam int unsigned WORDS  = BLK_N * BLK_N;
    localparam int unsigned ADDR_W = 2 * IDX_W;
    localparam int unsigned BIT_W  = $clog2(SAMPLE_W);

    logic              accept;
    logic [IDX_W-1:0]  row;
    logic [IDX_W-1:0]  col;
    logic [IDX_W-1:0]  tpos;
    logic [ADDR_W-1:0] waddr;
    logic              wr_done;
    logic              rd_done;
    bank_sel_t         wr_bank;
    bank_sel_t         rd_bank;
    logic [1:0]        full;
    logic              rd_active;
    logic [BIT_W-1:0]  bit_idx;

    // Producer handshake: accept only into an empty bank.
    assign in_ready = !full[wr_bank];
    assign accept   = in_valid && in_ready;
    assign waddr    = {row, tpos};

    dctr_write_ctrl #(.BLK_N(BLK_N)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .row      (row),
        .col      (col),
        .blk_done (wr_done)
    );

    dctr_index_map #(.BLK_N(BLK_N)) u_map (
        .row  (row),
        .col  (col),
        .tpos (tpos)
    );

    dctr_pingpong u_pp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_done (wr_done),
        .rd_done (rd_done),
        .wr_bank (wr_bank),
        .rd_bank (rd_bank),
        .full    (full)
    );

    dctr_read_ctrl #(.SAMPLE_W(SAMPLE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_ready (full[rd_bank]),
        .core_req   (core_req),
        .active     (rd_active),
        .bit_idx    (bit_idx),
        .pass_first (out_first),
        .pass_last  (out_last)
    );

    dctr_bank_store #(.WORDS(WORDS), .SAMPLE_W(SAMPLE_W)) u_mem (
        .clk   (clk),
        .we    (accept),
        .wbank (wr_bank),
        .waddr (waddr),
        .wdata (in_sample),
        .rbank (rd_bank),
        .rbit  (bit_idx),
        .slice (out_bits)
    );

    assign out_valid = rd_active;
    assign rd_done   = out_last;

    // R6: with both banks holding blocks the producer is held off.
    p_ready_low_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&full) |-> !in_ready);

    // R2: in row 0 the permutation is the identity.
    p_map_row0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (row == '0)) |-> (tpos == col));

    // R8: a pass only opens after the core asked for one.
    p_pass_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(core_req));

endmodule

// File: tb/tb_dct_in_reorder.sv
`timescale 1ns/1ps
module tb_dct_in_reorder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_sample = '0;
    logic        core_req = 1'b0;
    logic [63:0] out_bits;
    logic        out_valid;
    logic        out_first;
    logic        out_last;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    logic [8:0] got [64];

    always #2 clk = ~clk;

    dct_in_reorder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .core_req(core_req), .out_bits(out_bits),
        .out_valid(out_valid), .out_first(out_first), .out_last(out_last)
    );

    // Hand-computed permutation points: {raster index, stream index}.
    localparam int TBL [10][2] = '{
        '{0, 0}, '{7, 7}, '{8, 11}, '{9, 8}, '{14, 9},
        '{15, 14}, '{56, 61}, '{63, 56}, '{59, 60}, '{57, 58}
    };

    function automatic int pat(int sel, int k);
        case (sel)
            0: return k * 7 - 200;
            1: return (k % 3 == 0) ? 255 : (k % 3 == 1) ? -255 : ((k % 2) ? -1 : 1);
            2: return 100 - k * 3;
            3: return k * 5 - 150;
            4: return (k * 37) % 511 - 255;
            5: return -(k * 4);
            6: return 77;
            default: return 200 - k * 6;
        endcase
    endfunction

    // Destination column from the congruence in the requirement.
    function automatic int map_t(int n1, int n2);
        for (int tt = 0; tt < 8; tt++)
            if ((((4 * tt + 1) * (4 * n1 + 1)) % 32) == 4 * n2 + 1) return tt;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Offer one block word by word, retrying while in_ready is low.
    task automatic send_block(input int sel);
        int k = 0;
        while (k < 64) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 9'(pat(sel, k));
            if (in_ready) k++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Capture one pass into got[], checking the strobes (R4).
    task automatic capture_pass(input string tag);
        int n = 0;
        int bad = 0;
        while (!out_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(out_valid, {tag, " R8 pass never started"}, out_valid, 1);
        for (int b = 0; b < 9; b++) begin
            if (out_first != (b == 0) || out_last != (b == 8) || !out_valid) bad++;
            for (int i = 0; i < 64; i++) got[i][b] = out_bits[i];
            @(negedge clk);
        end
        if (out_valid) bad++;
        chk(bad == 0, {tag, " R4 strobes"}, bad, 0);
    endtask

    // Compare the captured words against the permuted block (R2, R3).
    task automatic check_block(input int sel, input string tag);
        int bad = 0;
        int first_bad = -1;
        for (int k = 0; k < 64; k++) begin
            int dst = (k / 8) * 8 + map_t(k / 8, k % 8);
            if (got[dst] != 9'(pat(sel, k))) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        chk(bad == 0, {tag, " R2 R3 word mismatches (count)"}, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        rst_n = 1'b1;

        // R5 latency, then R2/R3 on a ramp.
        core_req = 1'b1;
        send_block(0);
        chk(out_valid == 1'b0, "R5 idle cycle after last word", out_valid, 0);
        @(negedge clk);
        chk(out_valid && out_first, "R5 first bit after second edge", out_valid, 1);
        capture_pass("ramp");
        check_block(0, "ramp");
        for (int i = 0; i < 10; i++) begin
            chk(got[TBL[i][1]] == 9'(pat(0, TBL[i][0])), "R2 table point",
                int'($signed(got[TBL[i][1]])), pat(0, TBL[i][0]));
        end

        // R3: extremes and sign bit.
        send_block(1);
        capture_pass("extreme");
        check_block(1, "extreme");

        // R6/R7/R8: hold both banks full with the core idle.
        core_req = 1'b0;
        send_block(2);
        send_block(3);
        chk(in_ready == 1'b0, "R6 ready low with both banks full", in_ready, 0);
        begin
            int seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk(seen == 0, "R8 no pass without core_req", seen, 0);
        end
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 9'(c * 50);
        end
        @(negedge clk);
        in_valid = 1'b0;
        core_req = 1'b1;
        capture_pass("held-first");
        check_block(2, "R7 first held block");
        capture_pass("held-second");
        check_block(3, "R6 second held block intact");

        // R9: write the next block while the previous one streams.
        send_block(4);
        fork
            send_block(5);
            capture_pass("overlap-a");
        join
        check_block(4, "R9 streamed during write");
        capture_pass("overlap-b");
        check_block(5, "R9 written during stream");

        // R1: reset in the middle of a block.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 9'(pat(6, k));
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        chk(in_ready && !out_valid, "R1 mid-block reset", out_valid, 0);
        rst_n = 1'b1;
        send_block(7);
        capture_pass("after-reset");
        check_block(7, "R1 fresh block after reset");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule